// File: doc/BRIEF.md
# Mode-Split Complex Multiply-Accumulate Unit

This block is a two-stage pipelined multiply-accumulate engine on a 24-bit operand path with a 56-bit accumulator. One set of four signed 13x13 partial-product multipliers is reconfigured on every accepted operand pair. Depending on the operation class and a width status bit, they form:

- one full 24x24 signed product, or
- two independent 12x12 lane products, or
- a 12-bit complex product.

The accumulator can be read as one 56-bit value, or as two 28-bit halves. In the split modes, each half is an independent accumulator.

A host drives `a_i`/`b_i` with `valid_i` high, and may do so on every cycle. `clr_i` starts a new sum. The result appears on the accumulator outputs with `valid_o` two cycles later.

In complex mode each operand carries its real part in bits [23:12] and its imaginary part in bits [11:0]. The real result accumulates in the upper half and the imaginary result in the lower half.

Top module: `split_mode_mac`

## Requirements
- R1: With `cplx_i`=0 and `wide_i`=1 (scalar), the 56-bit accumulator adds the sign-extended signed product `a_i*b_i` of the two 24-bit operands, wrapping modulo 2^56.
- R2: With `cplx_i`=0 and `wide_i`=0 (dual lane), the upper 28-bit half adds `a_i[23:12]*b_i[23:12]` and the lower half adds `a_i[11:0]*b_i[11:0]`. Both lane products are signed. Each half wraps modulo 2^28, with no carry or borrow between halves.
- R3: With `cplx_i`=1 (complex), bits [23:12] of each operand are the real part and bits [11:0] the imaginary part, all signed. The upper half adds Ar*Br - Ai*Bi and the lower half adds Ar*Bi + Ai*Br, each wrapping modulo 2^28.
- R4: When `clr_i` is high with `valid_i`, the accumulator (or each half) is loaded with the new product instead of adding it.
- R5: `valid_o` is high exactly two cycles after each cycle with `valid_i` high, and the accumulator result of that pair is visible in the same cycle. A new pair is accepted every cycle.
- R6: A cycle with `valid_i` low leaves the accumulator unchanged.
- R7: After reset the accumulator reads zero and `valid_o` is low.
- R8: `acc_hi_o` always equals `acc_o[55:28]` and `acc_lo_o` always equals `acc_o[27:0]`.
- R9: In complex mode `wide_i` has no effect; the result is the 12-bit complex product of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand pair valid |
| cplx_i | input | 1 | Operation class: 1 selects complex multiply |
| wide_i | input | 1 | Width status bit for the real class: 1 = 24-bit scalar, 0 = dual 12-bit lanes |
| clr_i | input | 1 | Load the product instead of accumulating |
| a_i | input | 24 | Operand A |
| b_i | input | 24 | Operand B |
| valid_o | output | 1 | Result valid, two cycles after valid_i |
| acc_o | output | 56 | Full accumulator |
| acc_hi_o | output | 28 | Upper accumulator half (lane 1 / real) |
| acc_lo_o | output | 28 | Lower accumulator half (lane 0 / imaginary) |

## Verification
The following are checked by assertions on every cycle:

- the two-cycle valid latency;
- the accumulator holding steady on idle cycles;
- a clear loading exactly the staged product;
- each registered product staying inside the range its mode allows (a lane product never spilling into the neighbouring half).

The arithmetic itself can only be shown by the bench's scenarios, which compare the outputs every cycle against an integer model. Those scenarios cover:

- the most negative operands in every mode;
- a long accumulation that wraps each 28-bit half without disturbing the other;
- a scalar run that wraps the full 56 bits;
- status-bit changes in complex mode;
- a random mix of modes, clears and idle gaps.

// File: rtl/mac_split_pkg.sv
package mac_split_pkg;
  typedef enum logic [1:0] {
    MODE_SCALAR = 2'd0,
    MODE_SIMD   = 2'd1,
    MODE_CPLX   = 2'd2
  } mac_mode_e;
endpackage

// File: rtl/mac_mode_dec.sv
module mac_mode_dec
  import mac_split_pkg::*;
(
  input  logic      cplx_i,
  input  logic      wide_i,
  output mac_mode_e mode_o,
  output logic      split_o
);
  // complex class always runs on 12-bit parts; width bit only matters for the real class
  always_comb begin
    if (cplx_i)      mode_o = MODE_CPLX;
    else if (wide_i) mode_o = MODE_SCALAR;
    else             mode_o = MODE_SIMD;
  end

  assign split_o = (mode_o != MODE_SCALAR);
endmodule

// File: rtl/mac_prod_stage.sv
module mac_prod_stage
  import mac_split_pkg::*;
#(
  parameter int LANE_W = 12,
  parameter int ACC_W  = 56
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  mac_mode_e           mode_i,
  input  logic                split_i,
  input  logic                clr_i,
  input  logic [2*LANE_W-1:0] a_i,
  input  logic [2*LANE_W-1:0] b_i,
  output logic                vld_o,
  output logic                split_o,
  output logic                clr_o,
  output logic [ACC_W-1:0]    prod_o
);
  localparam int DATA_W = 2 * LANE_W;
  localparam int HALF_W = ACC_W / 2;
  localparam int EXT_W  = LANE_W + 1;
  localparam int PP_W   = 2 * EXT_W;
  localparam int PRD_W  = 2 * LANE_W + 1;
  localparam int FULL_W = 2 * DATA_W;

  logic signed [EXT_W-1:0] a_ext [2];
  logic signed [EXT_W-1:0] b_ext [2];
  logic signed [PP_W-1:0]  pp    [2][2];

  // upper lane always signed; lower lane signed only when it is its own value
  assign a_ext[1] = {a_i[DATA_W-1], a_i[DATA_W-1:LANE_W]};
  assign b_ext[1] = {b_i[DATA_W-1], b_i[DATA_W-1:LANE_W]};
  assign a_ext[0] = {split_i & a_i[LANE_W-1], a_i[LANE_W-1:0]};
  assign b_ext[0] = {split_i & b_i[LANE_W-1], b_i[LANE_W-1:0]};

  for (genvar gi = 0; gi < 2; gi++) begin : g_row
    for (genvar gj = 0; gj < 2; gj++) begin : g_col
      assign pp[gi][gj] = a_ext[gi] * b_ext[gj];
    end
  end

  logic signed [ACC_W-1:0]  full_w;
  logic signed [HALF_W-1:0] hi_w, lo_w;
  logic        [ACC_W-1:0]  prod_d;

  assign full_w = (ACC_W'(pp[1][1]) <<< DATA_W)
                + ((ACC_W'(pp[1][0]) + ACC_W'(pp[0][1])) <<< LANE_W)
                + ACC_W'(pp[0][0]);

  always_comb begin
    case (mode_i)
      MODE_CPLX: begin
        hi_w = HALF_W'(pp[1][1]) - HALF_W'(pp[0][0]);
        lo_w = HALF_W'(pp[1][0]) + HALF_W'(pp[0][1]);
      end
      default: begin
        hi_w = HALF_W'(pp[1][1]);
        lo_w = HALF_W'(pp[0][0]);
      end
    endcase
    prod_d = split_i ? {hi_w, lo_w} : full_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      split_o <= 1'b0;
      clr_o   <= 1'b0;
      prod_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        split_o <= split_i;
        clr_o   <= clr_i;
        prod_o  <= prod_d;
      end
    end
  end

  logic [HALF_W-PRD_W:0] hi_top, lo_top;
  logic [ACC_W-FULL_W:0] full_top;
  assign hi_top   = prod_o[ACC_W-1:HALF_W+PRD_W-1];
  assign lo_top   = prod_o[HALF_W-1:PRD_W-1];
  assign full_top = prod_o[ACC_W-1:FULL_W-1];

  // R2 R3
  lane_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && split_o |-> ((&hi_top) || !(|hi_top)) && ((&lo_top) || !(|lo_top)));

  // R1
  full_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !split_o |-> (&full_top) || !(|full_top));
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage #(
  parameter int ACC_W = 56
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             split_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic             vld_o,
  output logic [ACC_W-1:0] acc_o
);
  localparam int HALF_W = ACC_W / 2;

  logic [ACC_W-1:0]  base, acc_d;
  logic [HALF_W-1:0] sum_hi, sum_lo;

  always_comb begin
    base   = clr_i ? '0 : acc_o;
    sum_hi = base[ACC_W-1:HALF_W] + prod_i[ACC_W-1:HALF_W];
    sum_lo = base[HALF_W-1:0] + prod_i[HALF_W-1:0];
    acc_d  = split_i ? {sum_hi, sum_lo} : base + prod_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      acc_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) acc_o <= acc_d;
    end
  end

  // R6
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(acc_o));

  // R4
  clear_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && clr_i |=> acc_o == $past(prod_i));
endmodule

// File: rtl/split_mode_mac.sv
module split_mode_mac
  import mac_split_pkg::*;
#(
  parameter int LANE_W = 12,
  parameter int ACC_W  = 56
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  cplx_i,
  input  logic                  wide_i,
  input  logic                  clr_i,
  input  logic [2*LANE_W-1:0]   a_i,
  input  logic [2*LANE_W-1:0]   b_i,
  output logic                  valid_o,
  output logic [ACC_W-1:0]      acc_o,
  output logic [ACC_W/2-1:0]    acc_hi_o,
  output logic [ACC_W/2-1:0]    acc_lo_o
);
  localparam int HALF_W = ACC_W / 2;

  mac_mode_e        mode;
  logic             split;
  logic             s1_vld, s1_split, s1_clr;
  logic [ACC_W-1:0] s1_prod;

  mac_mode_dec u_dec (
    .cplx_i  (cplx_i),
    .wide_i  (wide_i),
    .mode_o  (mode),
    .split_o (split)
  );

  mac_prod_stage #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_prod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (valid_i),
    .mode_i  (mode),
    .split_i (split),
    .clr_i   (clr_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .vld_o   (s1_vld),
    .split_o (s1_split),
    .clr_o   (s1_clr),
    .prod_o  (s1_prod)
  );

  mac_acc_stage #(.ACC_W(ACC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (s1_vld),
    .split_i (s1_split),
    .clr_i   (s1_clr),
    .prod_i  (s1_prod),
    .vld_o   (valid_o),
    .acc_o   (acc_o)
  );

  assign acc_hi_o = acc_o[ACC_W-1:HALF_W];
  assign acc_lo_o = acc_o[HALF_W-1:0];

  // R5
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 2));
endmodule

// File: tb/split_mode_mac_tb.sv
module split_mode_mac_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, cplx_i = 1'b0, wide_i = 1'b0, clr_i = 1'b0;
  logic [23:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [55:0] acc_o;
  logic [27:0] acc_hi_o, acc_lo_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk_i = ~clk_i;

  split_mode_mac u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .cplx_i(cplx_i),
    .wide_i(wide_i), .clr_i(clr_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o),
    .acc_o(acc_o), .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o)
  );

  logic [55:0] m_acc = '0;
  bit          qv [$];
  logic [55:0] qa [$];
  string       qt [$];

  function automatic logic [55:0] ref_next(input logic [55:0] acc, input logic c, w, k,
                                           input logic [23:0] a, b);
    longint ah, al, bh, bl, full;
    logic [27:0] ph, pl, h, l;
    logic [55:0] base;
    ah = longint'($signed(a[23:12]));
    al = longint'($signed(a[11:0]));
    bh = longint'($signed(b[23:12]));
    bl = longint'($signed(b[11:0]));
    base = k ? 56'd0 : acc;
    if (!c && w) begin
      full = longint'($signed(a)) * longint'($signed(b));
      return base + 56'(full);
    end
    if (c) begin
      ph = 28'(ah * bh - al * bl);
      pl = 28'(ah * bl + al * bh);
    end else begin
      ph = 28'(ah * bh);
      pl = 28'(al * bl);
    end
    h = base[55:28] + ph;
    l = base[27:0] + pl;
    return {h, l};
  endfunction

  task automatic compare();
    bit ev;
    logic [55:0] ea;
    string et;
    ev = qv.pop_front();
    ea = qa.pop_front();
    et = qt.pop_front();
    n_cmp++;
    if (valid_o !== ev) begin
      n_bad++;
      $display("FAIL R5 valid_o actual=%0b expected=%0b", valid_o, ev);
    end
    n_cmp++;
    if (acc_o !== ea) begin
      n_bad++;
      $display("FAIL %s acc_o actual=%h expected=%h", et, acc_o, ea);
    end
    n_cmp++;
    if ({acc_hi_o, acc_lo_o} !== acc_o) begin
      n_bad++;
      $display("FAIL R8 halves actual=%h_%h expected=%h", acc_hi_o, acc_lo_o, acc_o);
    end
  endtask

  task automatic step(input bit v, c, w, k, input logic [23:0] a, b);
    string tag;
    @(negedge clk_i);
    if (qv.size() == 2) compare();
    valid_i = v; cplx_i = c; wide_i = w; clr_i = k; a_i = a; b_i = b;
    if (v) m_acc = ref_next(m_acc, c, w, k, a, b);
    if (!v)          tag = "R6";
    else if (k)      tag = "R4";
    else if (c && w) tag = "R9";
    else if (c)      tag = "R3";
    else if (w)      tag = "R1";
    else             tag = "R2";
    qv.push_back(v);
    qa.push_back(m_acc);
    qt.push_back(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R7: first two compared cycles must show the reset state
    repeat (2) begin qv.push_back(1'b0); qa.push_back('0); qt.push_back("R7"); end

    // R1 scalar, extremes
    step(1, 0, 1, 1, 24'h800000, 24'h800000);
    step(1, 0, 1, 0, 24'h7FFFFF, 24'h800000);
    step(1, 0, 1, 0, 24'hFFFFFF, 24'h000003);
    step(0, 0, 1, 0, 24'h123456, 24'h654321);
    step(1, 0, 1, 0, 24'h000123, 24'hFFF001);
    // R1 full-width wrap
    step(1, 0, 1, 1, 24'h800000, 24'h800000);
    for (int i = 0; i < 1100; i++) step(1, 0, 1, 0, 24'h800000, 24'h800000);

    // R2 lanes, no borrow across the boundary
    step(1, 0, 0, 1, 24'h000FFF, 24'h000001);
    step(1, 0, 0, 0, 24'h800800, 24'h800800);
    step(1, 0, 0, 0, 24'h7FF001, 24'h800FFF);
    // R2 per-half wrap
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 24'h800800, 24'h800800);

    // R3 complex
    step(1, 1, 0, 1, 24'h003004, 24'h005FFE);
    step(1, 1, 0, 0, 24'h800800, 24'h800800);
    step(1, 1, 0, 0, 24'h7FF800, 24'h8007FF);
    step(0, 1, 0, 0, 24'h0, 24'h0);
    // R9 width bit ignored for complex class
    step(1, 1, 1, 0, 24'h003004, 24'h005FFE);
    step(1, 1, 1, 1, 24'h800FFF, 24'h7FF800);

    // mixed random traffic, back to back with gaps
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, $urandom % 2, $urandom % 2, ($urandom % 8) == 0,
           24'($urandom), 24'($urandom));

    step(0, 0, 0, 0, '0, '0);
    step(0, 0, 0, 0, '0, '0);
    step(0, 0, 0, 0, '0, '0);
    finish_run();
  end
endmodule